// File: doc/BRIEF.md
# Memory Region Attribute Resolver

The resolver decides, for every memory reference, which caching mode applies and whether a write must be refused. It holds a small set of region descriptors and one global control word. Each descriptor carries an 8-bit base tag, an 8-bit don't-care mask, an enable bit, a write-protect bit and a 2-bit caching mode. The global word carries a cache-enable bit, a default write-protect bit, and separate default caching modes for instruction fetches and for data accesses.

The access path is purely combinational. The address, the access type and the read/write flag go in, and the same cycle gives back the effective mode, a cacheable flag, a write-protect violation flag and the index of the region that won. Descriptors are compared in fixed priority, with the lowest index first. An access that matches no enabled descriptor takes the global defaults. Configuration is written one word at a time through a select-and-write port and is registered.

Top module: `region_attr_resolver`

## Requirements
- R1: When region 0 matches, its attributes are used and `hit_idx` is 0, even if region 1 matches too.
- R2: When region 0 does not match and region 1 does, region 1's attributes are used and `hit_idx` is 1.
- R3: When no region matches, `hit_idx` is 2. The mode is then the global data default (global word bits [1:0]) for a data access (`acc_is_insn`=0) and the global instruction default (bits [5:4]) for an instruction access (`acc_is_insn`=1).
- R4: Matching looks only at address bits [31:24]. A region matches when those bits equal its base tag (descriptor bits [31:24]) at every position where its mask (descriptor bits [23:16]) holds 0. A mask bit of 1 makes that address bit a don't-care. Address bits [23:0] have no effect.
- R5: A region whose enable bit (descriptor bit 7) is 0 never matches.
- R6: `wp_violation` is 1 only for a write (`acc_is_write`=1). For a write it takes the write-protect bit of the matched region (descriptor bit 3). When no region matches, it takes the default write-protect bit (global bit 8).
- R7: `eff_cacheable` is 1 only when the cache-enable bit (global bit 31) is 1 and the effective mode is 00 (write-through) or 01 (copyback). Mode 10 is inhibited-precise and mode 11 is inhibited-imprecise.
- R8: After reset every descriptor and global bit is 0. Any access then gives `hit_idx`=2, `eff_mode`=00, `eff_cacheable`=0 and `wp_violation`=0.
- R9: A write with `cfg_we`=1 updates the word named by `cfg_sel` (0 = region 0, 1 = region 1, 2 = global) at the clock edge. The outputs show the old value up to that edge and the new value after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Word select: 0/1 region descriptor, 2 global control |
| cfg_wdata | input | 32 | Configuration write data |
| acc_addr | input | 32 | Access address |
| acc_is_insn | input | 1 | 1 = instruction fetch, 0 = data access |
| acc_is_write | input | 1 | 1 = write access |
| eff_mode | output | 2 | Effective caching mode |
| eff_cacheable | output | 1 | Access may be served by the cache |
| wp_violation | output | 1 | Write hits a write-protected space |
| hit_idx | output | 2 | Winning region index, 2 = defaults |

## Verification
Every access output depends only on the current access inputs and the stored configuration, so it is due in the same cycle as the stimulus. The bench applies access inputs on the falling edge and samples the outputs 2 ns later, well before the next rising edge. A configuration write counts for R9 only after the rising edge that captures it. The bench probes once before that edge, to confirm the old value still holds, and once after it, to confirm the new value.

// File: rtl/attr_pkg.sv
// Package: shared types and field positions for the region attribute resolver.
// Assumes 2-bit caching modes and 8-bit compare tags taken from the address top.
package attr_pkg;

    localparam int TAG_W = 8;

    typedef enum logic [1:0] {
        MODE_WT            = 2'b00,
        MODE_CB            = 2'b01,
        MODE_INH_PRECISE   = 2'b10,
        MODE_INH_IMPRECISE = 2'b11
    } cache_mode_t;

    typedef struct packed {
        logic [TAG_W-1:0] base;
        logic [TAG_W-1:0] mask;
        logic             enable;
        logic             wprot;
        cache_mode_t      mode;
    } region_desc_t;

    typedef struct packed {
        logic        cache_en;
        logic        dflt_wprot;
        cache_mode_t insn_mode;
        cache_mode_t data_mode;
    } glob_ctrl_t;

    // Field positions inside a 32-bit configuration word
    localparam int RD_BASE_LSB = 24;
    localparam int RD_MASK_LSB = 16;
    localparam int RD_EN_BIT   = 7;
    localparam int RD_WP_BIT   = 3;
    localparam int RD_MODE_LSB = 0;
    localparam int GC_EN_BIT   = 31;
    localparam int GC_WP_BIT   = 8;
    localparam int GC_IMODE_LSB = 4;
    localparam int GC_DMODE_LSB = 0;

endpackage

// File: rtl/attr_cfg_regs.sv
// Module: attr_cfg_regs
// Holds N_REGIONS region descriptors plus the global control word.
// A write with cfg_sel < N_REGIONS loads a descriptor. cfg_sel == N_REGIONS
// loads the global word. Other select values are ignored.
// Assumes synchronous active-low reset clearing every bit.
module attr_cfg_regs
    import attr_pkg::*;
#(
    parameter int N_REGIONS = 2,
    parameter int DATA_W    = 32,
    localparam int SEL_W    = $clog2(N_REGIONS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    output region_desc_t      regions [N_REGIONS],
    output glob_ctrl_t        gctrl
);

    region_desc_t wr_desc;
    glob_ctrl_t   wr_ctrl;

    // Unpack the write word into descriptor and global fields
    always_comb begin
        wr_desc.base   = cfg_wdata[RD_BASE_LSB +: TAG_W];
        wr_desc.mask   = cfg_wdata[RD_MASK_LSB +: TAG_W];
        wr_desc.enable = cfg_wdata[RD_EN_BIT];
        wr_desc.wprot  = cfg_wdata[RD_WP_BIT];
        wr_desc.mode   = cache_mode_t'(cfg_wdata[RD_MODE_LSB +: 2]);
        wr_ctrl.cache_en   = cfg_wdata[GC_EN_BIT];
        wr_ctrl.dflt_wprot = cfg_wdata[GC_WP_BIT];
        wr_ctrl.insn_mode  = cache_mode_t'(cfg_wdata[GC_IMODE_LSB +: 2]);
        wr_ctrl.data_mode  = cache_mode_t'(cfg_wdata[GC_DMODE_LSB +: 2]);
    end

    for (genvar g = 0; g < N_REGIONS; g++) begin : g_desc
        // Load descriptor g on a write that selects it
        always_ff @(posedge clk) begin
            if (!rst_n)
                regions[g] <= '0;
            else if (cfg_we && (cfg_sel == SEL_W'(g)))
                regions[g] <= wr_desc;
        end
    end

    // Load the global control word on a write that selects it
    always_ff @(posedge clk) begin
        if (!rst_n)
            gctrl <= '0;
        else if (cfg_we && (cfg_sel == SEL_W'(N_REGIONS)))
            gctrl <= wr_ctrl;
    end

    assert_gctrl_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel == SEL_W'(N_REGIONS)) |=>
        (gctrl.cache_en == $past(cfg_wdata[GC_EN_BIT]) &&
         gctrl.data_mode == $past(cfg_wdata[GC_DMODE_LSB +: 2])));

    assert_gctrl_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_we && cfg_sel == SEL_W'(N_REGIONS)) |=> $stable(gctrl));

endmodule

// File: rtl/attr_region_match.sv
// Module: attr_region_match
// Compares the upper TAG_W address bits to one descriptor's base tag.
// Mask bits of 1 are ignored. A disabled descriptor never matches.
module attr_region_match
    import attr_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  region_desc_t      desc,
    output logic              hit
);

    logic [TAG_W-1:0] tag;
    logic [TAG_W-1:0] diff;

    // Masked tag comparison gated by the enable bit
    always_comb begin
        tag  = addr[ADDR_W-1 -: TAG_W];
        diff = (tag ^ desc.base) & ~desc.mask;
        hit  = desc.enable && (diff == '0);
    end

    assert_disabled_no_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !desc.enable |-> !hit);

    assert_full_mask_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (desc.enable && (&desc.mask)) |-> hit);

endmodule

// File: rtl/attr_select.sv
// Module: attr_select
// Picks the lowest-index hit region, or the global defaults if none hits.
// Produces the mode, the cacheable flag and the write-protect violation.
module attr_select
    import attr_pkg::*;
#(
    parameter int N_REGIONS = 2,
    localparam int IDX_W    = $clog2(N_REGIONS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_REGIONS-1:0] hits,
    input  region_desc_t     regions [N_REGIONS],
    input  glob_ctrl_t       gctrl,
    input  logic             is_insn,
    input  logic             is_write,
    output cache_mode_t      mode,
    output logic             cacheable,
    output logic             wp_viol,
    output logic [IDX_W-1:0] idx
);

    logic wprot_sel;

    // Fixed-priority choice: scan from highest index so index 0 wins last
    always_comb begin
        idx       = IDX_W'(N_REGIONS);
        mode      = is_insn ? gctrl.insn_mode : gctrl.data_mode;
        wprot_sel = gctrl.dflt_wprot;
        for (int i = N_REGIONS - 1; i >= 0; i--) begin
            if (hits[i]) begin
                idx       = IDX_W'(i);
                mode      = regions[i].mode;
                wprot_sel = regions[i].wprot;
            end
        end
    end

    // Cacheable only with the cache on and a write-through or copyback mode
    always_comb begin
        cacheable = gctrl.cache_en && (mode == MODE_WT || mode == MODE_CB);
        wp_viol   = is_write && wprot_sel;
    end

    assert_first_region_wins_R1: assert property (@(posedge clk) disable iff (!rst_n)
        hits[0] |-> (idx == '0));

    assert_default_on_miss_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hits == '0) |-> (idx == IDX_W'(N_REGIONS)));

    assert_read_never_violates_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !is_write |-> !wp_viol);

    assert_cache_off_uncached_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !gctrl.cache_en |-> !cacheable);

endmodule

// File: rtl/region_attr_resolver.sv
// Module: region_attr_resolver (top)
// Resolves effective caching attributes for each access from registered
// region descriptors and global defaults. The access path is combinational.
// Assumes N_REGIONS + 1 fits in the hit_idx width.
module region_attr_resolver
    import attr_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int N_REGIONS = 2,
    localparam int SEL_W    = $clog2(N_REGIONS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_is_insn,
    input  logic              acc_is_write,
    output logic [1:0]        eff_mode,
    output logic              eff_cacheable,
    output logic              wp_violation,
    output logic [SEL_W-1:0]  hit_idx
);

    region_desc_t         regions [N_REGIONS];
    glob_ctrl_t           gctrl;
    logic [N_REGIONS-1:0] hits;
    cache_mode_t          mode_sel;

    attr_cfg_regs #(.N_REGIONS(N_REGIONS), .DATA_W(DATA_W)) cfg_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .regions(regions), .gctrl(gctrl)
    );

    for (genvar g = 0; g < N_REGIONS; g++) begin : g_match
        attr_region_match #(.ADDR_W(ADDR_W)) match_i (
            .clk(clk), .rst_n(rst_n), .addr(acc_addr),
            .desc(regions[g]), .hit(hits[g])
        );
    end

    attr_select #(.N_REGIONS(N_REGIONS)) sel_i (
        .clk(clk), .rst_n(rst_n), .hits(hits), .regions(regions),
        .gctrl(gctrl), .is_insn(acc_is_insn), .is_write(acc_is_write),
        .mode(mode_sel), .cacheable(eff_cacheable), .wp_viol(wp_violation),
        .idx(hit_idx)
    );

    // Drive the plain-typed mode port
    always_comb eff_mode = mode_sel;

endmodule

// File: tb/region_attr_resolver_tb_top.sv
module region_attr_resolver_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] acc_addr = '0;
    logic        acc_is_insn = 1'b0;
    logic        acc_is_write = 1'b0;
    logic [1:0]  eff_mode;
    logic        eff_cacheable;
    logic        wp_violation;
    logic [1:0]  hit_idx;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    region_attr_resolver dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .acc_addr(acc_addr), .acc_is_insn(acc_is_insn),
        .acc_is_write(acc_is_write), .eff_mode(eff_mode),
        .eff_cacheable(eff_cacheable), .wp_violation(wp_violation),
        .hit_idx(hit_idx)
    );

    function automatic logic [31:0] rdesc(input logic [7:0] base, input logic [7:0] mask,
                                          input logic en, input logic wp, input logic [1:0] mode);
        return {base, mask, 8'h00, en, 3'b000, wp, 1'b0, mode};
    endfunction

    function automatic logic [31:0] gword(input logic en, input logic wp,
                                          input logic [1:0] imode, input logic [1:0] dmode);
        return {en, 22'h0, wp, 2'b00, imode, 2'b00, dmode};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_cfg(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Apply an access on the falling edge and sample 2 ns later
    task automatic probe(input logic [31:0] a, input logic insn, input logic wr);
        @(negedge clk);
        acc_addr = a; acc_is_insn = insn; acc_is_write = wr;
        #2;
    endtask

    task automatic expect_all(input string req, input int idx, input int mode,
                              input int cach, input int wp);
        chk({req, " idx"}, hit_idx, idx);
        chk({req, " mode"}, eff_mode, mode);
        chk({req, " cacheable"}, eff_cacheable, cach);
        chk({req, " wp"}, wp_violation, wp);
    endtask

    task automatic t_reset_state;
        probe(32'h4A00_0000, 1'b0, 1'b1);
        expect_all("R8 reset write", 2, 0, 0, 0);
        probe(32'hFF12_3456, 1'b1, 1'b0);
        expect_all("R8 reset fetch", 2, 0, 0, 0);
    endtask

    task automatic t_defaults;
        wr_cfg(2'd2, gword(1'b1, 1'b1, 2'b10, 2'b01));
        probe(32'h5000_0000, 1'b0, 1'b0);
        expect_all("R3 data default", 2, 1, 1, 0);
        probe(32'h5000_0000, 1'b1, 1'b0);
        expect_all("R3 insn default R7 inhibited", 2, 2, 0, 0);
        probe(32'h5000_0000, 1'b0, 1'b1);
        chk("R6 default wp write", wp_violation, 1);
    endtask

    task automatic t_region1;
        wr_cfg(2'd1, rdesc(8'h40, 8'h0F, 1'b1, 1'b0, 2'b11));
        probe(32'h4A12_3456, 1'b0, 1'b1);
        expect_all("R2 region1 write", 1, 3, 0, 0);
        probe(32'h40FF_FFFF, 1'b1, 1'b0);
        chk("R4 low bits ignored idx", hit_idx, 1);
        probe(32'h5000_0000, 1'b0, 1'b0);
        chk("R4 masked miss idx", hit_idx, 2);
        probe(32'h3F00_0000, 1'b0, 1'b0);
        chk("R4 unmasked bit differs idx", hit_idx, 2);
    endtask

    task automatic t_priority;
        wr_cfg(2'd0, rdesc(8'h48, 8'h07, 1'b1, 1'b1, 2'b00));
        probe(32'h4A00_0000, 1'b0, 1'b1);
        expect_all("R1 both match", 0, 0, 1, 1);
        probe(32'h4A00_0000, 1'b0, 1'b0);
        chk("R6 region read no wp", wp_violation, 0);
        probe(32'h4100_0000, 1'b0, 1'b1);
        expect_all("R2 only region1", 1, 3, 0, 0);
    endtask

    task automatic t_disable;
        wr_cfg(2'd0, rdesc(8'h48, 8'h07, 1'b0, 1'b1, 2'b00));
        probe(32'h4A00_0000, 1'b0, 1'b0);
        chk("R5 disabled region0 idx", hit_idx, 1);
        wr_cfg(2'd1, rdesc(8'h40, 8'h0F, 1'b0, 1'b0, 2'b11));
        probe(32'h4A00_0000, 1'b0, 1'b0);
        chk("R5 both disabled idx", hit_idx, 2);
    endtask

    task automatic t_cache_off_and_timing;
        wr_cfg(2'd0, rdesc(8'h48, 8'h07, 1'b1, 1'b0, 2'b00));
        probe(32'h4800_0000, 1'b0, 1'b0);
        chk("R7 on WT cacheable", eff_cacheable, 1);
        // Write the global word with cache off and look before/after the edge
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'd2; cfg_wdata = gword(1'b0, 1'b0, 2'b01, 2'b00);
        #2;
        chk("R9 old value before edge", eff_cacheable, 1);
        @(negedge clk);
        cfg_we = 1'b0;
        #2;
        chk("R9 R7 new value after edge", eff_cacheable, 0);
        chk("R7 mode kept", eff_mode, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_defaults();
        t_region1();
        t_priority();
        t_disable();
        t_cache_off_and_timing();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #100000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule